// File: doc/BRIEF.md
# Three-Phase Pre-Driver Mode and Protection Sequencer

This block sits between the analog front end of a three-phase motor pre-driver and its six gate-drive pins. It takes already-decoded comparator flags for the speed-control level (below the power-save threshold, below the drive threshold, at or above the test threshold), two active-low external protection flags (a bridge-module error line and an overheat sensor line), a die over-temperature flag, a one-cycle Hall-change strobe and a 1 µs timebase tick. From these it chooses one of four operating states and gates the per-phase high-side and low-side commands coming from the PWM logic.

In the sleep state every gate is low, the Hall sensor supply is switched off and the speed-pulse outputs are asked to sit high. In standby the high sides stay off while the low sides give short refresh pulses that keep the bootstrap capacitors charged. When the motor is first started after sleep, a fixed precharge interval holds every low side on before the PWM commands pass through. While running, a stall timer watches the Hall strobe. If no Hall change arrives within the lock period, the high sides are cut until the next sleep. Over-temperature pauses that timer without clearing it. The test level raises a flag that asks the commutation logic for 120-degree drive at full duty.

Top module: `motor_mode_seq`

## Requirements
- R1: While the accepted mode is sleep (power-save), all six gate outputs are low and `hall_bias_en` is 0; after reset the block is in sleep.
- R2: In sleep, `fg_force_high` is 1 unless `ext_fault_n` is low; in every other state it is 0.
- R3: In standby, `gate_hi` is 000 and `gate_lo` is 111 for the first PULSE_US ticks of every REFRESH_US-tick period, counted from standby entry, and 000 otherwise.
- R4: The first entry into drive or test after leaving sleep (directly or through standby) passes through a precharge state lasting PRECHARGE_US ticks, with `gate_hi` = 000, `gate_lo` = 111 and `precharge_ovr` = 1.
- R5: In the run state, `gate_hi` and `gate_lo` follow `cmd_hi`/`cmd_lo` one cycle later; a return from standby to drive that has not passed through sleep skips precharge.
- R6: `test_mode` is 1 exactly while running with the test level accepted.
- R7: If no `hall_edge` arrives for LOCK_MS × US_PER_MS ticks while running, `lock_active` becomes 1 and `gate_hi` is forced to 000 while `gate_lo` still follows `cmd_lo`.
- R8: Only the sleep state clears `lock_active` and the stall count; standby or a Hall edge does not release an active lock.
- R9: While `die_hot` is 1 the stall count holds its value; it resumes from there when `die_hot` returns to 0.
- R10: `ext_fault_n` = 0 or `overheat_n` = 0 forces all six gate outputs low; `ext_fault_n` = 0 also sets `fg_off` = 1.
- R11: A mode flag change is accepted only after two consecutive equal synchronised samples: a one-cycle glitch has no effect, and a held change reaches the outputs on the sixth rising edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lvl_below_save | input | 1 | Control level under the power-save threshold |
| lvl_below_drive | input | 1 | Control level under the drive threshold |
| lvl_above_test | input | 1 | Control level at or over the test threshold |
| ext_fault_n | input | 1 | Bridge-module error, active low |
| overheat_n | input | 1 | External overheat sensor, active low |
| die_hot | input | 1 | Die over-temperature flag |
| hall_edge | input | 1 | One-cycle strobe on any Hall state change |
| tick_us | input | 1 | One-cycle strobe every microsecond |
| cmd_hi | input | 3 | High-side commands from PWM logic, one per phase |
| cmd_lo | input | 3 | Low-side commands from PWM logic, one per phase |
| gate_hi | output | 3 | Gated high-side enables |
| gate_lo | output | 3 | Gated low-side enables |
| precharge_ovr | output | 1 | Precharge override active |
| hall_bias_en | output | 1 | Hall sensor supply enable |
| fg_force_high | output | 1 | Speed-pulse outputs forced high |
| fg_off | output | 1 | Speed-pulse outputs switched off |
| test_mode | output | 1 | Request for 120-degree full-duty drive |
| lock_active | output | 1 | Stall protection engaged |

## Verification
Results fall due at fixed distances: a PWM command appears on the gates one edge later, a protection flag three edges later (two synchroniser stages and the output register), and a control-level change six edges later (synchroniser, two-sample filter, state register, output register). The bench keeps a behavioural model that advances on the same edges and compares every output at the falling edge, so each result is sampled in the cycle it is due; spot checks wait well past these distances before looking at the ports, and the glitch check uses the exact count.

// File: rtl/motor_seq_pkg.sv
package motor_seq_pkg;
  typedef enum logic [1:0] {MD_SAVE, MD_STBY, MD_DRIVE, MD_TEST} mode_e;
  typedef enum logic [1:0] {ST_SAVE, ST_STBY, ST_PRECH, ST_RUN} state_e;

  // flag vector bit positions
  localparam int FB_SAVE  = 0;
  localparam int FB_DRIVE = 1;
  localparam int FB_TEST  = 2;
  localparam int FB_FAULT = 3;
  localparam int FB_OVH   = 4;
  localparam int FB_HOT   = 5;
  localparam int FLAG_W   = 6;
  localparam logic [FLAG_W-1:0] FLAG_RST = 6'b011011;

  function automatic mode_e decode_mode(input logic below_save, input logic below_drive,
                                        input logic above_test);
    if (below_save)       return MD_SAVE;
    else if (below_drive) return MD_STBY;
    else if (above_test)  return MD_TEST;
    else                  return MD_DRIVE;
  endfunction
endpackage

// File: rtl/mode_filter.sv
module mode_filter
  import motor_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FLAG_W-1:0] flags_raw,
  output mode_e             mode_acc,
  output logic              fault_ok,
  output logic              ovh_ok,
  output logic              hot
);
  logic [FLAG_W-1:0] stage_q [SYNC_STAGES];
  logic [FLAG_W-1:0] flags_s;
  mode_e dec, dec_prev_q, acc_q;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[i] <= FLAG_RST;
        else     stage_q[i] <= flags_raw;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[i] <= FLAG_RST;
        else     stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign flags_s = stage_q[SYNC_STAGES-1];
  assign dec = decode_mode(flags_s[FB_SAVE], flags_s[FB_DRIVE], flags_s[FB_TEST]);

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_prev_q <= MD_SAVE;
      acc_q      <= MD_SAVE;
    end else begin
      dec_prev_q <= dec;
      if (dec == dec_prev_q) acc_q <= dec;
    end
  end

  assign mode_acc = acc_q;
  assign fault_ok = flags_s[FB_FAULT];
  assign ovh_ok   = flags_s[FB_OVH];
  assign hot      = flags_s[FB_HOT];

  // R11
  accept_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_q != $past(acc_q)) |-> (acc_q == $past(dec_prev_q)));
endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
  import motor_seq_pkg::*;
#(
  parameter int PRECHARGE_US = 3840,
  parameter int REFRESH_US   = 1000,
  parameter int PULSE_US     = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  mode_e  mode_acc,
  input  logic   tick_us,
  output state_e state,
  output logic   refresh_on
);
  localparam int PC_W = $clog2(PRECHARGE_US + 1);
  localparam int RF_W = $clog2(REFRESH_US);
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(PRECHARGE_US - 1);
  localparam logic [RF_W-1:0] RF_LAST = RF_W'(REFRESH_US - 1);
  localparam logic [RF_W-1:0] RF_PULSE = RF_W'(PULSE_US);

  state_e st_q, st_d;
  logic armed_q;
  logic [PC_W-1:0] pc_q;
  logic [RF_W-1:0] rf_q;

  always_comb begin
    st_d = st_q;
    if (mode_acc == MD_SAVE) begin
      st_d = ST_SAVE;
    end else if (mode_acc == MD_STBY) begin
      st_d = ST_STBY;
    end else begin
      unique case (st_q)
        ST_SAVE:  st_d = ST_PRECH;
        ST_STBY:  st_d = armed_q ? ST_PRECH : ST_RUN;
        ST_PRECH: if (tick_us && pc_q == PC_LAST) st_d = ST_RUN;
        ST_RUN:   st_d = ST_RUN;
        default:  st_d = ST_SAVE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_SAVE;
      armed_q <= 1'b1;
      pc_q    <= '0;
      rf_q    <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_SAVE) armed_q <= 1'b1;
      else if (st_q == ST_PRECH && st_d == ST_RUN) armed_q <= 1'b0;
      if (st_q != ST_PRECH) pc_q <= '0;
      else if (tick_us)     pc_q <= pc_q + 1'b1;
      if (st_q != ST_STBY)  rf_q <= '0;
      else if (tick_us)     rf_q <= (rf_q == RF_LAST) ? '0 : rf_q + 1'b1;
    end
  end

  assign state      = st_q;
  assign refresh_on = (st_q == ST_STBY) && (rf_q < RF_PULSE);

  // R4
  prech_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_PRECH && st_d == ST_PRECH) |-> armed_q);
endmodule

// File: rtl/stall_timer.sv
module stall_timer #(
  parameter int LOCK_MS   = 2000,
  parameter int US_PER_MS = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  input  logic freeze,
  input  logic hall_edge,
  input  logic tick_us,
  output logic locked
);
  localparam int US_W = $clog2(US_PER_MS);
  localparam int MS_W = $clog2(LOCK_MS);
  localparam logic [US_W-1:0] US_LAST = US_W'(US_PER_MS - 1);
  localparam logic [MS_W-1:0] MS_LAST = MS_W'(LOCK_MS - 1);

  logic [US_W-1:0] us_q;
  logic [MS_W-1:0] ms_q;
  logic lock_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      us_q   <= '0;
      ms_q   <= '0;
      lock_q <= 1'b0;
    end else if (hall_edge) begin
      us_q <= '0;
      ms_q <= '0;
    end else if (run && !freeze && !lock_q && tick_us) begin
      if (us_q == US_LAST) begin
        us_q <= '0;
        if (ms_q == MS_LAST) begin
          ms_q   <= '0;
          lock_q <= 1'b1;
        end else begin
          ms_q <= ms_q + 1'b1;
        end
      end else begin
        us_q <= us_q + 1'b1;
      end
    end
  end

  assign locked = lock_q;

  // R8
  clear_release_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> !lock_q);
  // R9
  freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (freeze && !clear && !hall_edge) |=> ($stable(ms_q) && $stable(us_q)));
endmodule

// File: rtl/motor_mode_seq.sv
module motor_mode_seq
  import motor_seq_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int PRECHARGE_US = 3840,
  parameter int REFRESH_US   = 1000,
  parameter int PULSE_US     = 2,
  parameter int LOCK_MS      = 2000,
  parameter int US_PER_MS    = 1000,
  parameter int PHASES       = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lvl_below_save,
  input  logic              lvl_below_drive,
  input  logic              lvl_above_test,
  input  logic              ext_fault_n,
  input  logic              overheat_n,
  input  logic              die_hot,
  input  logic              hall_edge,
  input  logic              tick_us,
  input  logic [PHASES-1:0] cmd_hi,
  input  logic [PHASES-1:0] cmd_lo,
  output logic [PHASES-1:0] gate_hi,
  output logic [PHASES-1:0] gate_lo,
  output logic              precharge_ovr,
  output logic              hall_bias_en,
  output logic              fg_force_high,
  output logic              fg_off,
  output logic              test_mode,
  output logic              lock_active
);
  mode_e  mode_acc;
  state_e state;
  logic fault_ok, ovh_ok, hot, refresh_on, locked, blocked;
  logic [FLAG_W-1:0] flags_raw;

  assign flags_raw = {die_hot, overheat_n, ext_fault_n, lvl_above_test, lvl_below_drive,
                      lvl_below_save};

  mode_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filter (
    .clk(clk), .rst(rst), .flags_raw(flags_raw), .mode_acc(mode_acc),
    .fault_ok(fault_ok), .ovh_ok(ovh_ok), .hot(hot));

  mode_fsm #(.PRECHARGE_US(PRECHARGE_US), .REFRESH_US(REFRESH_US), .PULSE_US(PULSE_US)) u_fsm (
    .clk(clk), .rst(rst), .mode_acc(mode_acc), .tick_us(tick_us), .state(state),
    .refresh_on(refresh_on));

  stall_timer #(.LOCK_MS(LOCK_MS), .US_PER_MS(US_PER_MS)) u_stall (
    .clk(clk), .rst(rst), .clear(state == ST_SAVE), .run(state == ST_RUN), .freeze(hot),
    .hall_edge(hall_edge), .tick_us(tick_us), .locked(locked));

  assign blocked = !fault_ok || !ovh_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_hi       <= '0;
      gate_lo       <= '0;
      precharge_ovr <= 1'b0;
      hall_bias_en  <= 1'b0;
      fg_force_high <= 1'b1;
      fg_off        <= 1'b0;
      test_mode     <= 1'b0;
    end else begin
      gate_hi <= '0;
      gate_lo <= '0;
      if (!blocked) begin
        unique case (state)
          ST_STBY:  gate_lo <= {PHASES{refresh_on}};
          ST_PRECH: gate_lo <= '1;
          ST_RUN: begin
            gate_hi <= cmd_hi & ~{PHASES{locked}};
            gate_lo <= cmd_lo;
          end
          default: ;
        endcase
      end
      precharge_ovr <= (state == ST_PRECH);
      hall_bias_en  <= (state != ST_SAVE);
      fg_force_high <= (state == ST_SAVE) && fault_ok;
      fg_off        <= !fault_ok;
      test_mode     <= (state == ST_RUN) && (mode_acc == MD_TEST);
    end
  end

  assign lock_active = locked;

  // R1
  save_gates_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SAVE) |=> (gate_hi == '0 && gate_lo == '0 && !hall_bias_en));
  // R3
  stby_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STBY) |=> (gate_hi == '0));
  // R7
  lock_hi_chk: assert property (@(posedge clk) disable iff (rst)
    locked |=> (gate_hi == '0));
  // R10
  fault_gates_chk: assert property (@(posedge clk) disable iff (rst)
    blocked |=> (gate_hi == '0 && gate_lo == '0));
endmodule

// File: tb/tb_motor_mode_seq.sv
`timescale 1ns/1ps
module tb_motor_mode_seq;
  localparam int PRE = 40, REF = 10, PUL = 2, LMS = 4, UPM = 5;

  logic clk = 0, rst = 1;
  logic below_save = 1, below_drive = 1, above_test = 0;
  logic fault_n = 1, ovh_n = 1, hot = 0, hall = 0, tick = 1;
  logic [2:0] chi = 0, clo = 0;
  logic [2:0] g_hi, g_lo;
  logic pre, hb, fgh, fgoff, tmode, lock;
  int checks = 0, errors = 0, cyc = 0;
  logic hall_en = 0;
  int hall_cnt = 0;

  always #2.5 clk = ~clk;

  motor_mode_seq #(.PRECHARGE_US(PRE), .REFRESH_US(REF), .PULSE_US(PUL), .LOCK_MS(LMS),
                   .US_PER_MS(UPM)) dut (
    .clk(clk), .rst(rst), .lvl_below_save(below_save), .lvl_below_drive(below_drive),
    .lvl_above_test(above_test), .ext_fault_n(fault_n), .overheat_n(ovh_n), .die_hot(hot),
    .hall_edge(hall), .tick_us(tick), .cmd_hi(chi), .cmd_lo(clo), .gate_hi(g_hi),
    .gate_lo(g_lo), .precharge_ovr(pre), .hall_bias_en(hb), .fg_force_high(fgh),
    .fg_off(fgoff), .test_mode(tmode), .lock_active(lock));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // behavioural reference model: states 0 sleep,1 standby,2 precharge,3 run
  // modes 0 sleep,1 standby,2 drive,3 test
  logic [5:0] m1, m2;
  int mprev, macc, mst, marmed, mpc, mrf, mus, mms, mlock;
  int e_hi, e_lo, e_pre, e_hb, e_fgh, e_fgoff, e_test;

  function automatic int mode_of(input logic [5:0] f);
    if (f[0]) return 0;
    if (f[1]) return 1;
    if (f[2]) return 3;
    return 2;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m1 = 6'b011011; m2 = 6'b011011; mprev = 0; macc = 0; mst = 0; marmed = 1;
      mpc = 0; mrf = 0; mus = 0; mms = 0; mlock = 0;
      e_hi = 0; e_lo = 0; e_pre = 0; e_hb = 0; e_fgh = 1; e_fgoff = 0; e_test = 0;
    end else begin
      int nst, d;
      bit blk;
      blk = !m2[3] || !m2[4];
      e_hi = (mst == 3 && !blk) ? int'(chi & ~{3{mlock[0]}}) : 0;
      if (blk) e_lo = 0;
      else if (mst == 1) e_lo = (mrf < PUL) ? 7 : 0;
      else if (mst == 2) e_lo = 7;
      else if (mst == 3) e_lo = int'(clo);
      else e_lo = 0;
      e_pre = (mst == 2); e_hb = (mst != 0); e_fgh = (mst == 0) && m2[3];
      e_fgoff = !m2[3]; e_test = (mst == 3) && (macc == 3);
      if (mst == 0) begin mus = 0; mms = 0; mlock = 0; end
      else if (hall) begin mus = 0; mms = 0; end
      else if (mst == 3 && !m2[5] && mlock == 0 && tick) begin
        mus++;
        if (mus == UPM) begin mus = 0; mms++; if (mms == LMS) begin mms = 0; mlock = 1; end end
      end
      nst = mst;
      if (macc == 0) nst = 0;
      else if (macc == 1) nst = 1;
      else if (mst == 0) nst = 2;
      else if (mst == 1) nst = marmed ? 2 : 3;
      else if (mst == 2 && tick && mpc == PRE - 1) nst = 3;
      if (mst == 0) marmed = 1;
      else if (mst == 2 && nst == 3) marmed = 0;
      if (mst != 2) mpc = 0; else if (tick) mpc++;
      if (mst != 1) mrf = 0; else if (tick) mrf = (mrf == REF - 1) ? 0 : mrf + 1;
      mst = nst;
      d = mode_of(m2);
      if (d == mprev) macc = d;
      mprev = d; m2 = m1;
      m1 = {hot, ovh_n, fault_n, above_test, below_drive, below_save};
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R5 gate_hi", int'(g_hi), e_hi);
      chk("R3 gate_lo", int'(g_lo), e_lo);
      chk("R4 precharge_ovr", int'(pre), e_pre);
      chk("R1 hall_bias_en", int'(hb), e_hb);
      chk("R2 fg_force_high", int'(fgh), e_fgh);
      chk("R10 fg_off", int'(fgoff), e_fgoff);
      chk("R6 test_mode", int'(tmode), e_test);
      chk("R7 lock_active", int'(lock), mlock);
    end
  end

  // background Hall strobes
  always @(negedge clk) begin
    hall_cnt++;
    hall <= hall_en && (hall_cnt % 8 == 0);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      chk("watchdog", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int cnt, cnt2;
    wait_n(5);
    rst = 0;
    wait_n(2);
    // R1 R2: reset state
    chk("R1 reset gates", int'({g_hi, g_lo}), 0);
    chk("R1 reset bias", int'(hb), 0);
    chk("R2 reset fg high", int'(fgh), 1);
    // R11: one-cycle glitch ignored
    below_save = 0; wait_n(1); below_save = 1;
    wait_n(10);
    chk("R11 glitch ignored", int'(hb), 0);
    // R11: held change arrives on sixth edge
    below_save = 0;
    wait_n(5);
    chk("R11 not before sixth edge", int'(hb), 0);
    wait_n(1);
    chk("R11 sixth edge", int'(hb), 1);
    // R3: standby refresh pulses
    wait_n(5);
    cnt = 0; cnt2 = 0;
    for (int i = 0; i < 30; i++) begin
      wait_n(1);
      if (g_lo == 3'b111) cnt++;
      if (g_hi != 0) cnt2++;
    end
    chk("R3 refresh pulse count", cnt, 6);
    chk("R3 high side off", cnt2, 0);
    // R4: precharge on first drive after sleep
    hall_en = 1; chi = 3'b101; clo = 3'b010;
    below_drive = 0;
    cnt = 0; cnt2 = 0;
    for (int i = 0; i < 70; i++) begin
      wait_n(1);
      if (pre) begin cnt++; if (g_lo != 3'b111 || g_hi != 0) cnt2++; end
    end
    chk("R4 precharge length", cnt, PRE);
    chk("R4 precharge gates", cnt2, 0);
    chk("R5 hi follows", int'(g_hi), 5);
    chk("R5 lo follows", int'(g_lo), 2);
    chi = 3'b011; clo = 3'b100; wait_n(1);
    chk("R5 one cycle", int'({g_hi, g_lo}), 6'b011100);
    // R5: standby then drive skips precharge
    below_drive = 1; wait_n(20);
    below_drive = 0;
    cnt = 0;
    for (int i = 0; i < 40; i++) begin wait_n(1); if (pre) cnt++; end
    chk("R5 no second precharge", cnt, 0);
    chk("R5 running again", int'(g_hi), 3);
    // R6: test level
    above_test = 1; wait_n(10);
    chk("R6 test flag", int'(tmode), 1);
    above_test = 0; wait_n(10);
    chk("R6 test flag off", int'(tmode), 0);
    // R7: stall lock
    hall_en = 0; wait_n(40);
    chk("R7 locked", int'(lock), 1);
    chk("R7 high sides cut", int'(g_hi), 0);
    chk("R7 low sides pass", int'(g_lo), 4);
    // R8: standby and hall do not release
    below_drive = 1; wait_n(20); below_drive = 0; hall_en = 1; wait_n(20);
    chk("R8 lock kept", int'(lock), 1);
    below_save = 1; below_drive = 1; wait_n(10);
    chk("R8 sleep clears", int'(lock), 0);
    // R9: over-temperature freezes count
    below_save = 0; below_drive = 0; wait_n(70);
    hall_en = 0; wait_n(6);
    hot = 1; wait_n(50);
    chk("R9 frozen", int'(lock), 0);
    hot = 0; wait_n(40);
    chk("R9 resumes", int'(lock), 1);
    // R10: protection inputs
    below_save = 1; wait_n(10); below_save = 0; hall_en = 1; wait_n(70);
    fault_n = 0; wait_n(5);
    chk("R10 fault gates", int'({g_hi, g_lo}), 0);
    chk("R10 fault fg off", int'(fgoff), 1);
    fault_n = 1; wait_n(5);
    chk("R10 recovered", int'(g_hi), 3);
    ovh_n = 0; wait_n(5);
    chk("R10 overheat gates", int'({g_hi, g_lo}), 0);
    chk("R10 overheat fg", int'(fgoff), 0);
    ovh_n = 1;
    // R2: fault in sleep suppresses forced-high
    below_save = 1; wait_n(10);
    chk("R2 fg high in sleep", int'(fgh), 1);
    fault_n = 0; wait_n(5);
    chk("R2 fault wins", int'(fgh), 0);
    fault_n = 1; wait_n(5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule